// File: doc/BRIEF.md
# Scan-Loaded Configuration Register Bank

This block sits behind a four-bit test-access instruction register. It gives serial access to the configuration state of a synchronous line buffer. The state consists of one 8-bit control word and two address reload values, one for reading and one for writing. The block also offers a sample-only view of the two address counters, which arrive as input ports. An external TAP sequencer drives the capture, shift and update strobes for both the instruction path and the data path, all timed on the test clock.

The committed instruction selects which data chain sits between `tdi` and `tdo`. The choices are the control word, either reload value, both reload values as one 32-bit chain, the counter snapshot, or a 1-bit bypass stage. Every chain shifts least significant bit first. `tdo` always shows bit 0 of the chain that is active. A parallel register changes only at the Update-DR strobe. At Capture-IR the instruction stage is preloaded with the combined-load code, so a sequencer can commit that code without shifting any instruction bits in.

Top module: `scan_cfg_bank`

## Requirements
- R1: After `trst_n` is released, the control word and both reload registers are all zeros and the active instruction is 1111 (bypass).
- R2: With instruction 0010 the data chain is 8 bits long. Capture-DR loads zeros into it, so the first eight bits on `tdo` are 0 whatever the control word holds. Update-DR copies the eight shifted bits into the control word.
- R3: The control word fields are ordered as follows. Bits 2:0 drive `expand_id`, bit 3 drives `wr_reload_en`, bit 4 drives `wr_count_down`, bit 5 drives `rd_reload_en`, bit 6 drives `rd_count_down` and bit 7 drives `oe_sync`.
- R4: Instruction 0011 selects a 16-bit chain for the read reload register, and instruction 0100 selects a 16-bit chain for the write reload register. Capture-DR loads the register's current value, so the old value shifts out while the new value shifts in.
- R5: Instruction 0101 selects one 32-bit chain. The first 16 bits shifted in go to the write reload register and the next 16 go to the read reload register. On capture, bits 15:0 of the chain hold the write value and bits 31:16 hold the read value.
- R6: Capture-IR loads 0101 into the instruction stage. A Capture-IR followed directly by Update-IR makes 0101 the active instruction. If the stage is shifted instead, `tdo` shows 1,0,1,0.
- R7: Instruction 0110 captures a 32-bit chain with `wr_count` in bits 15:0 and `rd_count` in bits 31:16. An Update-DR under this instruction leaves the control word and both reload registers unchanged.
- R8: The control word and both reload registers keep their values through Capture-DR and Shift-DR. They change only at Update-DR.
- R9: Instruction 1111 and every code not listed above select a 1-bit bypass chain. It captures 0 and delays `tdi` by one shift.
- R10: Instruction bits shift in least significant bit first. The active instruction changes only at Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| cap_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| upd_ir | input | 1 | Update-IR state strobe |
| cap_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| wr_count | input | ADDR_W | Write address counter value to sample |
| rd_count | input | ADDR_W | Read address counter value to sample |
| tdo | output | 1 | Serial data out, bit 0 of the active chain |
| active_instr | output | 4 | Committed instruction |
| expand_id | output | 3 | Depth-expansion identifier |
| wr_reload_en | output | 1 | Write counter: 1 = reload from register, 0 = clear |
| wr_count_down | output | 1 | Write counter: 1 = count down |
| rd_reload_en | output | 1 | Read counter: 1 = reload from register, 0 = clear |
| rd_count_down | output | 1 | Read counter: 1 = count down |
| oe_sync | output | 1 | Output-enable mode: 1 = synchronous |
| wr_reload | output | ADDR_W | Write reload register |
| rd_reload | output | ADDR_W | Read reload register |

## Verification
The bench builds the block with the default `ADDR_W` of 16. This gives full 16-bit reload chains and a 32-bit combined chain and count chain. With that width, the bench can tell apart a write-then-read ordering from a swapped one by using distinct halves such as 0x9ABC and 0xDEF0. The bench also scans a chain twice in a row. The bits from the first scan then come back out of the second, which exposes any capture of the wrong source, and any early update during shifting.

// File: rtl/scan_cfg_bank.sv
module scan_cfg_bank #(
  parameter int ADDR_W = 16
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              cap_ir,
  input  logic              shift_ir,
  input  logic              upd_ir,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic [ADDR_W-1:0] wr_count,
  input  logic [ADDR_W-1:0] rd_count,
  output logic              tdo,
  output logic [3:0]        active_instr,
  output logic [2:0]        expand_id,
  output logic              wr_reload_en,
  output logic              wr_count_down,
  output logic              rd_reload_en,
  output logic              rd_count_down,
  output logic              oe_sync,
  output logic [ADDR_W-1:0] wr_reload,
  output logic [ADDR_W-1:0] rd_reload
);
  localparam int CTRL_W  = 8;
  localparam int CHAIN_W = 2 * ADDR_W;
  localparam logic [3:0] OP_CTRL = 4'b0010;
  localparam logic [3:0] OP_RRLD = 4'b0011;
  localparam logic [3:0] OP_WRLD = 4'b0100;
  localparam logic [3:0] OP_BOTH = 4'b0101;
  localparam logic [3:0] OP_CNT  = 4'b0110;
  localparam logic [3:0] OP_BYP  = 4'b1111;

  typedef enum logic [2:0] {SEL_BYP, SEL_CTRL, SEL_RRLD, SEL_WRLD, SEL_BOTH, SEL_CNT} sel_t;

  logic [3:0]         ir_sr, ir;
  logic [CHAIN_W-1:0] dr_sr, cap_val, shift_val;
  logic [CTRL_W-1:0]  ctrl;
  logic [ADDR_W-1:0]  wr_rld, rd_rld;
  sel_t               sel;
  int                 chain_len;

  always_comb begin
    case (ir)
      OP_CTRL: begin sel = SEL_CTRL; chain_len = CTRL_W;  end
      OP_RRLD: begin sel = SEL_RRLD; chain_len = ADDR_W;  end
      OP_WRLD: begin sel = SEL_WRLD; chain_len = ADDR_W;  end
      OP_BOTH: begin sel = SEL_BOTH; chain_len = CHAIN_W; end
      OP_CNT:  begin sel = SEL_CNT;  chain_len = CHAIN_W; end
      default: begin sel = SEL_BYP;  chain_len = 1;       end
    endcase
  end

  always_comb begin
    cap_val = '0;
    case (sel)
      SEL_RRLD: cap_val[ADDR_W-1:0] = rd_rld;
      SEL_WRLD: cap_val[ADDR_W-1:0] = wr_rld;
      SEL_BOTH: cap_val = {rd_rld, wr_rld};
      SEL_CNT:  cap_val = {rd_count, wr_count};
      default:  cap_val = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < CHAIN_W; i++) begin
      if (i == chain_len - 1)     shift_val[i] = tdi;
      else if (i < chain_len - 1) shift_val[i] = dr_sr[i+1];
      else                        shift_val[i] = 1'b0;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= '0;
      ir     <= OP_BYP;
      dr_sr  <= '0;
      ctrl   <= '0;
      wr_rld <= '0;
      rd_rld <= '0;
    end else begin
      if (cap_ir)        ir_sr <= OP_BOTH;
      else if (shift_ir) ir_sr <= {tdi, ir_sr[3:1]};
      if (upd_ir)        ir    <= ir_sr;
      if (cap_dr)        dr_sr <= cap_val;
      else if (shift_dr) dr_sr <= shift_val;
      if (upd_dr) begin
        case (sel)
          SEL_CTRL: ctrl   <= dr_sr[CTRL_W-1:0];
          SEL_RRLD: rd_rld <= dr_sr[ADDR_W-1:0];
          SEL_WRLD: wr_rld <= dr_sr[ADDR_W-1:0];
          SEL_BOTH: begin
            wr_rld <= dr_sr[ADDR_W-1:0];
            rd_rld <= dr_sr[CHAIN_W-1:ADDR_W];
          end
          default: ;
        endcase
      end
    end
  end

  assign tdo           = shift_ir ? ir_sr[0] : dr_sr[0];
  assign active_instr  = ir;
  assign expand_id     = ctrl[2:0];
  assign wr_reload_en  = ctrl[3];
  assign wr_count_down = ctrl[4];
  assign rd_reload_en  = ctrl[5];
  assign rd_count_down = ctrl[6];
  assign oe_sync       = ctrl[7];
  assign wr_reload     = wr_rld;
  assign rd_reload     = rd_rld;
endmodule

// File: rtl/scan_cfg_bank_chk.sv
module scan_cfg_bank_chk #(
  parameter int ADDR_W = 16
) (
  input logic              tck,
  input logic              trst_n,
  input logic              cap_ir,
  input logic              shift_ir,
  input logic              upd_ir,
  input logic              cap_dr,
  input logic              upd_dr,
  input logic              tdo,
  input logic [3:0]        active_instr,
  input logic [3:0]        ir_sr_q,
  input logic [7:0]        ctrl_q,
  input logic [ADDR_W-1:0] wr_q,
  input logic [ADDR_W-1:0] rd_q
);
  AST_CTRL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_dr |=> $stable(ctrl_q)); // R8
  AST_RELOAD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_dr |=> $stable({wr_q, rd_q})); // R8
  AST_IR_PRELOAD: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir |=> (ir_sr_q == 4'b0101)); // R6
  AST_INSTR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_ir |=> $stable(active_instr)); // R10
  AST_COUNT_READONLY: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_dr && active_instr == 4'b0110) |=> $stable({ctrl_q, wr_q, rd_q})); // R7
  AST_CTRL_ZERO_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && active_instr == 4'b0010) |=> (shift_ir || !tdo)); // R2
endmodule

bind scan_cfg_bank scan_cfg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .cap_ir(cap_ir), .shift_ir(shift_ir),
  .upd_ir(upd_ir), .cap_dr(cap_dr), .upd_dr(upd_dr), .tdo(tdo),
  .active_instr(active_instr), .ir_sr_q(ir_sr), .ctrl_q(ctrl),
  .wr_q(wr_rld), .rd_q(rd_rld)
);

// File: tb/tb_scan_cfg_bank.sv
`timescale 1ns/100ps
module tb_scan_cfg_bank;
  localparam int ADDR_W = 16;
  logic tck = 0, trst_n = 0, tdi = 0;
  logic cap_ir = 0, shift_ir = 0, upd_ir = 0, cap_dr = 0, shift_dr = 0, upd_dr = 0;
  logic [ADDR_W-1:0] wr_count = '0, rd_count = '0;
  logic tdo, wr_reload_en, wr_count_down, rd_reload_en, rd_count_down, oe_sync;
  logic [3:0] active_instr;
  logic [2:0] expand_id;
  logic [ADDR_W-1:0] wr_reload, rd_reload;
  int checks = 0, errors = 0;

  always #2.5 tck = ~tck;

  scan_cfg_bank #(.ADDR_W(ADDR_W)) dut (.*);

  // instr | len | data in | expected data out
  localparam logic [73:0] TBL [10] = '{
    {4'b0010, 6'd8,  32'h0000_00A5, 32'h0000_0000},
    {4'b0010, 6'd8,  32'h0000_003C, 32'h0000_0000},
    {4'b0100, 6'd16, 32'h0000_1234, 32'h0000_0000},
    {4'b0100, 6'd16, 32'h0000_BEEF, 32'h0000_1234},
    {4'b0011, 6'd16, 32'h0000_5678, 32'h0000_0000},
    {4'b0101, 6'd32, 32'h9ABC_DEF0, 32'h5678_BEEF},
    {4'b0011, 6'd16, 32'h0000_0000, 32'h0000_9ABC},
    {4'b0100, 6'd16, 32'h0000_FFFF, 32'h0000_DEF0},
    {4'b1111, 6'd3,  32'h0000_0005, 32'h0000_0002},
    {4'b1010, 6'd3,  32'h0000_0003, 32'h0000_0006}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] shout);
    @(negedge tck); cap_ir = 1;
    @(negedge tck); cap_ir = 0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge tck);
      shift_ir = 1; tdi = code[k]; #1 shout[k] = tdo;
    end
    @(negedge tck); shift_ir = 0; upd_ir = 1;
    @(negedge tck); upd_ir = 0;
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, input bit upd, output logic [31:0] dout);
    dout = '0;
    @(negedge tck); cap_dr = 1;
    @(negedge tck); cap_dr = 0;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge tck);
      shift_dr = 1; tdi = din[k]; #1 dout[k] = tdo;
    end
    @(negedge tck); shift_dr = 0; upd_dr = upd;
    @(negedge tck); upd_dr = 0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] ir_out;
    logic [31:0] dout;
    repeat (3) @(negedge tck);
    trst_n = 1;
    #1;
    chk({oe_sync, rd_count_down, rd_reload_en, wr_count_down, wr_reload_en, expand_id} == 8'h00,
        "R1 ctrl", {24'h0, oe_sync, rd_count_down, rd_reload_en, wr_count_down, wr_reload_en, expand_id}, 0);
    chk(wr_reload == 0 && rd_reload == 0, "R1 reloads", {wr_reload, rd_reload}, 0);
    chk(active_instr == 4'b1111, "R1 instr", {28'h0, active_instr}, 32'hF);

    for (int i = 0; i < 10; i++) begin
      logic [3:0] op; logic [5:0] len; logic [31:0] din, exp;
      {op, len, din, exp} = TBL[i];
      load_ir(op, ir_out);
      chk(active_instr == op, "R10 instr commit", {28'h0, active_instr}, {28'h0, op});
      scan_dr(int'(len), din, 1'b1, dout);
      chk(dout == exp, "R2 R4 R5 R9 chain out", dout, exp);
    end
    chk(expand_id == 3'd4 && wr_reload_en && wr_count_down && rd_reload_en && !rd_count_down && !oe_sync,
        "R3 fields 3C", {29'h0, expand_id}, 32'h4);
    chk(wr_reload == 16'hFFFF, "R4 wr reload", {16'h0, wr_reload}, 32'hFFFF);
    chk(rd_reload == 16'h0000, "R4 rd reload", {16'h0, rd_reload}, 0);

    load_ir(4'b0010, ir_out);
    scan_dr(8, 32'hC3, 1'b1, dout);
    chk(expand_id == 3'd3 && !wr_reload_en && !wr_count_down && !rd_reload_en && rd_count_down && oe_sync,
        "R3 fields C3", {29'h0, expand_id}, 32'h3);
    chk(dout == 0, "R2 zero capture", dout, 0);

    chk(ir_out == 4'b0101, "R6 ir capture out", {28'h0, ir_out}, 32'h5);
    @(negedge tck); cap_ir = 1;
    @(negedge tck); cap_ir = 0; upd_ir = 1;
    @(negedge tck); upd_ir = 0;
    chk(active_instr == 4'b0101, "R6 preload commit", {28'h0, active_instr}, 32'h5);

    scan_dr(32, 32'h1111_2222, 1'b0, dout);
    chk(wr_reload == 16'hFFFF && rd_reload == 16'h0000, "R8 hold no update", {wr_reload, rd_reload}, 32'hFFFF0000);
    @(negedge tck); upd_dr = 1;
    @(negedge tck); upd_dr = 0;
    chk(wr_reload == 16'h2222 && rd_reload == 16'h1111, "R5 R8 late update", {wr_reload, rd_reload}, 32'h22221111);

    @(negedge tck); cap_ir = 1;
    @(negedge tck); cap_ir = 0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge tck);
      shift_ir = 1; tdi = k[0];
    end
    @(negedge tck); shift_ir = 0;
    #1 chk(active_instr == 4'b0101, "R10 hold during shift", {28'h0, active_instr}, 32'h5);
    @(negedge tck); upd_ir = 1;
    @(negedge tck); upd_ir = 0;
    chk(active_instr == 4'b1010, "R10 lsb first", {28'h0, active_instr}, 32'hA);

    wr_count = 16'h1357; rd_count = 16'h2468;
    load_ir(4'b0110, ir_out);
    scan_dr(32, 32'hFFFF_FFFF, 1'b1, dout);
    chk(dout == 32'h2468_1357, "R7 count capture", dout, 32'h24681357);
    chk(wr_reload == 16'h2222 && rd_reload == 16'h1111 && expand_id == 3'd3 && oe_sync,
        "R7 no effect", {wr_reload, rd_reload}, 32'h22221111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule